// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Wait-State Merging

This block turns the status and address of a bus cycle into a set of active-low chip-select strobes. Each select has its own programmed window, given as a start address and a block size. It also decodes either memory space or I/O space, and carries its own wait-state count and a flag that says whether it waits on an external ready line. Windows may overlap. When several selects match one cycle, their timing settings are merged into one effective wait count and one ready policy. The block then times the cycle with its own counter and raises a one-cycle done strobe at the end.

Configuration is written one select at a time through a simple write port. A cycle is offered with a single-cycle start pulse carrying the status code, the address and an initiator tag. The tag names the processor, the DMA engine or the refresh engine, and it has no effect on decoding. A status flag also reports any I/O cycle that falls in the small I/O window reserved for a coprocessor interface.

Top module: `csel_decoder`

## Requirements
- R1: Status codes 3 (memory read), 4 (memory write) and 5 (instruction fetch) can only activate selects programmed for memory space. Codes 1 (I/O read) and 2 (I/O write) can only activate selects programmed for I/O space (cfg_io = 1).
- R2: Status codes 0 (idle), 6 (halt) and 7 leave every cs_n bit high and cyc_busy low.
- R3: A select matches when start <= address < start + size, with the sum taken one bit wider than the address. A select with size 0 never matches. After reset, all selects have size 0.
- R4: The initiator tag (0 processor, 1 DMA, 2 refresh) has no effect on cs_n, cyc_ws or cyc_rdy_req.
- R5: If every matching select has ready disabled, the cycle reports cyc_rdy_req = 0 and cyc_ws equal to the largest wait count among them.
- R6: If any matching select has ready enabled, the cycle reports cyc_rdy_req = 1 and cyc_ws equal to the smallest wait count among all matching selects.
- R7: If no select matches a valid cycle, all cs_n bits stay high, cyc_busy still rises, and the cycle uses 3 wait states with ready required.
- R8: The cs_n bit of each matching select goes low on the clock edge that samples cyc_start. When ready is not required, cs_n stays low for exactly cyc_ws + 1 cycles, and cyc_done is high in the last of these cycles whatever bus_ready does.
- R9: When ready is required, cyc_done is high in the first busy cycle, counted from 0, whose index is at least cyc_ws and in which bus_ready is high.
- R10: cs_n is stable for the whole cycle. It returns to all ones on the edge after cyc_done. A cyc_start that arrives while cyc_busy is high is ignored.
- R11: cop_io_hit is high for the whole cycle of an I/O-space cycle whose address is in 0x00F8 to 0x00FF. It stays low for memory cycles and for other addresses.
- R12: A synchronous reset drives cs_n to all ones, cyc_busy and cyc_done low, and disables every select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for one select's settings |
| cfg_sel | input | 2 | Index of the select being written |
| cfg_start | input | 16 | Window start address |
| cfg_size | input | 16 | Window size in bytes; 0 disables the select |
| cfg_io | input | 1 | 1 = decode I/O space, 0 = memory space |
| cfg_ws | input | 4 | Wait-state count |
| cfg_rdy | input | 1 | 1 = select waits on bus_ready |
| cyc_start | input | 1 | Start of a cycle's address phase (one-cycle pulse) |
| cyc_status | input | 3 | Bus status code |
| cyc_init | input | 2 | Initiator tag |
| cyc_addr | input | 16 | Cycle address |
| bus_ready | input | 1 | External ready |
| cs_n | output | 4 | Active-low chip selects |
| cyc_busy | output | 1 | A cycle is in progress |
| cyc_done | output | 1 | Last cycle of the bus cycle |
| cyc_ws | output | 4 | Effective wait count of the current cycle |
| cyc_rdy_req | output | 1 | Current cycle waits on bus_ready |
| cop_io_hit | output | 1 | Current cycle is I/O in the coprocessor window |

## Verification
The bench sets up overlapping windows whose wait counts and ready flags are mixed. A merge that used the wrong extreme, or that ignored the ready flag of one member, shows up as a wrong cyc_ws or a wrong cycle length. It probes the last address inside a window and the first address past its end, as well as zero-size windows. An off-by-one compare or a disabled select that still fires would assert a stray strobe. It also sends memory cycles into I/O windows, idle and halt codes, and a start pulse in the middle of a cycle. A decoder that ignored the space bit, treated idle as a cycle, or relaunched mid-cycle would move cs_n or stretch the cycle. Ready is held low for a while after the count expires on cycles that require it, and toggled on cycles that ignore it. This separates a counter that samples ready too early, or at all, from a correct one.

// File: rtl/csel_pkg.sv
package csel_pkg;

   typedef enum logic [2:0] {
      BS_IDLE   = 3'd0,
      BS_IO_RD  = 3'd1,
      BS_IO_WR  = 3'd2,
      BS_MEM_RD = 3'd3,
      BS_MEM_WR = 3'd4,
      BS_FETCH  = 3'd5,
      BS_HALT   = 3'd6,
      BS_RSVD   = 3'd7
   } bus_stat_e;

   typedef enum logic [1:0] {
      INI_CPU     = 2'd0,
      INI_DMA     = 2'd1,
      INI_REFRESH = 2'd2,
      INI_SPARE   = 2'd3
   } init_e;

   function automatic logic stat_is_mem(input logic [2:0] s);
      return (s == BS_MEM_RD) || (s == BS_MEM_WR) || (s == BS_FETCH);
   endfunction

   function automatic logic stat_is_io(input logic [2:0] s);
      return (s == BS_IO_RD) || (s == BS_IO_WR);
   endfunction

endpackage

// File: rtl/csel_region.sv
module csel_region #(
   parameter int ADDR_W = 16,
   parameter int WS_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_start,
   input  logic [ADDR_W-1:0] wr_size,
   input  logic              wr_io,
   input  logic [WS_W-1:0]   wr_ws,
   input  logic              wr_rdy,
   input  logic [ADDR_W-1:0] q_addr,
   input  logic              q_is_mem,
   input  logic              q_is_io,
   output logic              hit,
   output logic [WS_W-1:0]   ws,
   output logic              rdy_en
);

   localparam int EXT_W = ADDR_W + 1;

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] size_q;
   logic              io_q;
   logic [WS_W-1:0]   ws_q;
   logic              rdy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         size_q <= '0;
         io_q   <= 1'b0;
         ws_q   <= '0;
         rdy_q  <= 1'b0;
      end else if (wr_en) begin
         base_q <= wr_start;
         size_q <= wr_size;
         io_q   <= wr_io;
         ws_q   <= wr_ws;
         rdy_q  <= wr_rdy;
      end
   end

   logic [EXT_W-1:0] limit;
   logic             in_win;
   logic             space_ok;

   always_comb begin
      limit    = {1'b0, base_q} + {1'b0, size_q};
      in_win   = (size_q != '0) && (q_addr >= base_q) &&
                 ({1'b0, q_addr} < limit);
      space_ok = io_q ? q_is_io : q_is_mem;
      hit      = in_win && space_ok;
   end

   assign ws     = ws_q;
   assign rdy_en = rdy_q;

endmodule

// File: rtl/csel_merge.sv
module csel_merge #(
   parameter int NUM_CS  = 4,
   parameter int WS_W    = 4,
   parameter int DEF_WS  = 3,
   parameter bit DEF_RDY = 1'b1
) (
   input  logic [NUM_CS-1:0]           hit,
   input  logic [NUM_CS-1:0][WS_W-1:0] ws,
   input  logic [NUM_CS-1:0]           rdy,
   output logic [WS_W-1:0]             eff_ws,
   output logic                        eff_rdy
);

   logic [WS_W-1:0] ws_max;
   logic [WS_W-1:0] ws_min;
   logic            any_hit;
   logic            any_rdy;

   always_comb begin
      ws_max  = '0;
      ws_min  = '1;
      any_hit = 1'b0;
      any_rdy = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (hit[i]) begin
            any_hit = 1'b1;
            if (rdy[i])        any_rdy = 1'b1;
            if (ws[i] > ws_max) ws_max = ws[i];
            if (ws[i] < ws_min) ws_min = ws[i];
         end
      end
      if (!any_hit) begin
         eff_ws  = WS_W'(DEF_WS);
         eff_rdy = DEF_RDY;
      end else if (any_rdy) begin
         eff_ws  = ws_min;
         eff_rdy = 1'b1;
      end else begin
         eff_ws  = ws_max;
         eff_rdy = 1'b0;
      end
   end

endmodule

// File: rtl/csel_waitctl.sv
module csel_waitctl #(
   parameter int NUM_CS = 4,
   parameter int WS_W   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              launch,
   input  logic [NUM_CS-1:0] hit,
   input  logic [WS_W-1:0]   eff_ws,
   input  logic              eff_rdy,
   input  logic              cop_in,
   input  logic              bus_ready,
   output logic [NUM_CS-1:0] cs_n,
   output logic              busy,
   output logic              done,
   output logic [WS_W-1:0]   ws_q,
   output logic              rdy_q,
   output logic              cop_q
);

   logic [WS_W-1:0] cnt;

   assign done = busy && (cnt == '0) && (!rdy_q || bus_ready);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         cs_n  <= '1;
         cnt   <= '0;
         ws_q  <= '0;
         rdy_q <= 1'b0;
         cop_q <= 1'b0;
      end else if (!busy) begin
         if (launch) begin
            busy  <= 1'b1;
            cs_n  <= ~hit;
            cnt   <= eff_ws;
            ws_q  <= eff_ws;
            rdy_q <= eff_rdy;
            cop_q <= cop_in;
         end
      end else if (done) begin
         busy  <= 1'b0;
         cs_n  <= '1;
         cop_q <= 1'b0;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
   import csel_pkg::*;
#(
   parameter int NUM_CS      = 4,
   parameter int ADDR_W      = 16,
   parameter int WS_W        = 4,
   parameter int DEF_WS      = 3,
   parameter bit DEF_RDY     = 1'b1,
   parameter bit COP_EN      = 1'b1,
   parameter int COP_BASE    = 'h00F8,
   parameter int COP_SPAN_LG = 3,
   localparam int SEL_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_start,
   input  logic [ADDR_W-1:0] cfg_size,
   input  logic              cfg_io,
   input  logic [WS_W-1:0]   cfg_ws,
   input  logic              cfg_rdy,
   input  logic              cyc_start,
   input  logic [2:0]        cyc_status,
   input  logic [1:0]        cyc_init,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic              bus_ready,
   output logic [NUM_CS-1:0] cs_n,
   output logic              cyc_busy,
   output logic              cyc_done,
   output logic [WS_W-1:0]   cyc_ws,
   output logic              cyc_rdy_req,
   output logic              cop_io_hit
);

   if (NUM_CS < 1 || NUM_CS > 32) begin : g_bad_num
      $error("csel_decoder: NUM_CS out of range");
   end
   if (WS_W < 1 || DEF_WS >= (1 << WS_W)) begin : g_bad_ws
      $error("csel_decoder: DEF_WS does not fit WS_W");
   end
   if (COP_SPAN_LG >= ADDR_W) begin : g_bad_cop
      $error("csel_decoder: coprocessor span too wide");
   end

   logic is_mem;
   logic is_io;
   logic launch;
   logic unused_init;

   assign is_mem      = stat_is_mem(cyc_status);
   assign is_io       = stat_is_io(cyc_status);
   assign launch      = cyc_start && (is_mem || is_io);
   assign unused_init = ^cyc_init;

   logic [NUM_CS-1:0]           hit;
   logic [NUM_CS-1:0][WS_W-1:0] ws_vec;
   logic [NUM_CS-1:0]           rdy_vec;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_region
      csel_region #(
         .ADDR_W (ADDR_W),
         .WS_W   (WS_W)
      ) u_region (
         .clk      (clk),
         .rst      (rst),
         .wr_en    (cfg_we && (cfg_sel == SEL_W'(g))),
         .wr_start (cfg_start),
         .wr_size  (cfg_size),
         .wr_io    (cfg_io),
         .wr_ws    (cfg_ws),
         .wr_rdy   (cfg_rdy),
         .q_addr   (cyc_addr),
         .q_is_mem (is_mem),
         .q_is_io  (is_io),
         .hit      (hit[g]),
         .ws       (ws_vec[g]),
         .rdy_en   (rdy_vec[g])
      );
   end

   logic [WS_W-1:0] eff_ws;
   logic            eff_rdy;

   csel_merge #(
      .NUM_CS  (NUM_CS),
      .WS_W    (WS_W),
      .DEF_WS  (DEF_WS),
      .DEF_RDY (DEF_RDY)
   ) u_merge (
      .hit     (hit),
      .ws      (ws_vec),
      .rdy     (rdy_vec),
      .eff_ws  (eff_ws),
      .eff_rdy (eff_rdy)
   );

   logic cop_hit;

   if (COP_EN) begin : g_cop
      localparam logic [ADDR_W-1:0] COP_B = ADDR_W'(COP_BASE);
      assign cop_hit = is_io &&
         (cyc_addr[ADDR_W-1:COP_SPAN_LG] == COP_B[ADDR_W-1:COP_SPAN_LG]);
   end else begin : g_no_cop
      assign cop_hit = 1'b0;
   end

   csel_waitctl #(
      .NUM_CS (NUM_CS),
      .WS_W   (WS_W)
   ) u_wait (
      .clk       (clk),
      .rst       (rst),
      .launch    (launch),
      .hit       (hit),
      .eff_ws    (eff_ws),
      .eff_rdy   (eff_rdy),
      .cop_in    (cop_hit),
      .bus_ready (bus_ready),
      .cs_n      (cs_n),
      .busy      (cyc_busy),
      .done      (cyc_done),
      .ws_q      (cyc_ws),
      .rdy_q     (cyc_rdy_req),
      .cop_q     (cop_io_hit)
   );

endmodule

// File: rtl/csel_checker.sv
module csel_checker #(
   parameter int NUM_CS = 4,
   parameter int WS_W   = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cyc_start,
   input logic              bus_ready,
   input logic [NUM_CS-1:0] cs_n,
   input logic              cyc_busy,
   input logic              cyc_done,
   input logic [WS_W-1:0]   cyc_ws,
   input logic              cyc_rdy_req,
   input logic              cop_io_hit
);

   logic [15:0] len;

   always_ff @(posedge clk) begin
      if (rst || !cyc_busy) len <= '0;
      else if (len != '1)   len <= len + 1'b1;
   end

   // R10
   idle_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
      !cyc_busy |-> (&cs_n && !cop_io_hit));

   // R10
   hold_cs_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_busy && !cyc_done) |=> (cyc_busy && $stable(cs_n) && $stable(cyc_ws)));

   // R10
   release_cs_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_done |=> (&cs_n && !cyc_busy));

   // R8
   fixed_len_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_done && !cyc_rdy_req) |-> (len == 16'(cyc_ws)));

   // R9
   ready_end_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_done && cyc_rdy_req) |-> (bus_ready && len >= 16'(cyc_ws)));

   // R9
   no_early_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_busy && cyc_rdy_req && bus_ready && len >= 16'(cyc_ws)) |-> cyc_done);

   // R10
   no_relaunch_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_busy && !cyc_done && cyc_start) |=> $stable(cs_n));

endmodule

bind csel_decoder csel_checker #(
   .NUM_CS (NUM_CS),
   .WS_W   (WS_W)
) u_csel_chk (
   .clk         (clk),
   .rst         (rst),
   .cyc_start   (cyc_start),
   .bus_ready   (bus_ready),
   .cs_n        (cs_n),
   .cyc_busy    (cyc_busy),
   .cyc_done    (cyc_done),
   .cyc_ws      (cyc_ws),
   .cyc_rdy_req (cyc_rdy_req),
   .cop_io_hit  (cop_io_hit)
);

// File: tb/test_csel_decoder.sv
`timescale 1ns/1ps
module test_csel_decoder;

   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_we;
   logic [1:0]  cfg_sel;
   logic [15:0] cfg_start;
   logic [15:0] cfg_size;
   logic        cfg_io;
   logic [3:0]  cfg_ws;
   logic        cfg_rdy;
   logic        cyc_start;
   logic [2:0]  cyc_status;
   logic [1:0]  cyc_init;
   logic [15:0] cyc_addr;
   logic        bus_ready;
   logic [3:0]  cs_n;
   logic        cyc_busy;
   logic        cyc_done;
   logic [3:0]  cyc_ws;
   logic        cyc_rdy_req;
   logic        cop_io_hit;

   always #2.5 clk = ~clk;

   csel_decoder i_csel_decoder (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_start(cfg_start), .cfg_size(cfg_size), .cfg_io(cfg_io),
      .cfg_ws(cfg_ws), .cfg_rdy(cfg_rdy), .cyc_start(cyc_start),
      .cyc_status(cyc_status), .cyc_init(cyc_init), .cyc_addr(cyc_addr),
      .bus_ready(bus_ready), .cs_n(cs_n), .cyc_busy(cyc_busy),
      .cyc_done(cyc_done), .cyc_ws(cyc_ws), .cyc_rdy_req(cyc_rdy_req),
      .cop_io_hit(cop_io_hit)
   );

   int n_chk = 0;
   int n_bad = 0;

   int m_start [N];
   int m_size  [N];
   bit m_io    [N];
   int m_ws    [N];
   bit m_rdy   [N];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_mem(input int s);
      return s == 3 || s == 4 || s == 5;
   endfunction

   function automatic bit is_io(input int s);
      return s == 1 || s == 2;
   endfunction

   function automatic int exp_hits(input int a, input int s);
      int h = 0;
      for (int i = 0; i < N; i++)
         if (m_size[i] != 0 && a >= m_start[i] && a < m_start[i] + m_size[i] &&
             (m_io[i] ? is_io(s) : is_mem(s)))
            h |= (1 << i);
      return h;
   endfunction

   function automatic int exp_rdy(input int h);
      if (h == 0) return 1;
      for (int i = 0; i < N; i++) if (h[i] && m_rdy[i]) return 1;
      return 0;
   endfunction

   function automatic int exp_ws(input int h);
      int mx = 0;
      int mn = 15;
      if (h == 0) return 3;
      for (int i = 0; i < N; i++)
         if (h[i]) begin
            if (m_ws[i] > mx) mx = m_ws[i];
            if (m_ws[i] < mn) mn = m_ws[i];
         end
      return exp_rdy(h) ? mn : mx;
   endfunction

   task automatic prog(input int idx, input int st, input int sz, input bit io,
                       input int ws, input bit rdy);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(idx); cfg_start = 16'(st); cfg_size = 16'(sz);
      cfg_io = io; cfg_ws = 4'(ws); cfg_rdy = rdy;
      @(negedge clk);
      cfg_we = 1'b0;
      m_start[idx] = st; m_size[idx] = sz; m_io[idx] = io;
      m_ws[idx] = ws; m_rdy[idx] = rdy;
   endtask

   // thr: busy-cycle index from which bus_ready is driven high on ready cycles
   task automatic run_cyc(input int a, input int s, input int ini, input int thr,
                          input bit poke, input string tag);
      int h, ew, er, len;
      bit ec;
      logic [3:0] cs0;
      h  = exp_hits(a, s);
      ew = exp_ws(h);
      er = exp_rdy(h);
      ec = is_io(s) && a >= 'hF8 && a <= 'hFF;
      @(negedge clk);
      cyc_start = 1'b1; cyc_addr = 16'(a); cyc_status = 3'(s); cyc_init = 2'(ini);
      @(negedge clk);
      cyc_start = 1'b0;
      if (!(is_mem(s) || is_io(s))) begin
         // R2
         chk(&cs_n && !cyc_busy, {tag, " R2 no select on non-bus status"},
             {cyc_busy, cs_n}, 'hF);
         return;
      end
      cs0 = cs_n;
      // R1 R3 R7
      chk(cs_n == ~4'(h), {tag, " R1/R3 select pattern"}, cs_n, ~h & 'hF);
      chk(cyc_busy == 1'b1, {tag, " R7 busy rises"}, cyc_busy, 1);
      // R5 R6
      chk(cyc_ws == 4'(ew), {tag, " R5/R6 merged wait count"}, cyc_ws, ew);
      chk(cyc_rdy_req == er[0], {tag, " R5/R6 ready policy"}, cyc_rdy_req, er);
      // R11
      chk(cop_io_hit == ec, {tag, " R11 coprocessor flag"}, cop_io_hit, ec);
      len = 0;
      for (int k = 0; k < 64; k++) begin
         bus_ready = er ? (k >= thr) : 1'($urandom % 2);
         #1;
         if (cs_n != cs0) chk(0, {tag, " R10 select held"}, cs_n, cs0);
         if (cyc_done) begin len = k + 1; break; end
         if (poke && k == 0) begin
            cyc_start = 1'b1; cyc_addr = cyc_addr ^ 16'h0040; cyc_status = 3'd3;
         end
         @(negedge clk);
         cyc_start = 1'b0;
      end
      if (er) begin
         // R9
         chk(len == ((thr > ew) ? thr : ew) + 1, {tag, " R9 ready cycle length"},
             len, ((thr > ew) ? thr : ew) + 1);
      end else begin
         // R8
         chk(len == ew + 1, {tag, " R8 fixed cycle length"}, len, ew + 1);
      end
      @(negedge clk);
      bus_ready = 1'b0;
      // R10
      chk(&cs_n && !cyc_busy && !cop_io_hit, {tag, " R10 release after done"},
          {cyc_busy, cs_n}, 'hF);
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C5D));
      rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_start = 0; cfg_size = 0; cfg_io = 0;
      cfg_ws = 0; cfg_rdy = 0; cyc_start = 0; cyc_status = 0; cyc_init = 0;
      cyc_addr = 0; bus_ready = 0;
      for (int i = 0; i < N; i++) begin
         m_start[i] = 0; m_size[i] = 0; m_io[i] = 0; m_ws[i] = 0; m_rdy[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R12
      chk(&cs_n && !cyc_busy && !cyc_done, "R12 reset state", {cyc_busy, cs_n}, 'hF);
      rst = 1'b0;
      // R12: all selects disabled, default timing R7
      run_cyc('h0000, 3, 0, 0, 0, "rst");
      run_cyc('h1234, 1, 0, 5, 0, "rst-io");

      // R5: 3 and 9, both ignore ready -> 9
      prog(0, 'h100, 'h100, 0, 3, 0);
      prog(1, 'h180, 'h100, 0, 9, 0);
      run_cyc('h1A0, 3, 0, 0, 0, "R5 ovl");
      // R6: 5 required + 0 ignored -> 0 required
      prog(0, 'h100, 'h100, 0, 5, 1);
      prog(1, 'h180, 'h100, 0, 0, 0);
      run_cyc('h1A0, 4, 0, 4, 0, "R6 ovl");
      // R6: 2 and 2 required
      prog(0, 'h100, 'h100, 0, 2, 1);
      prog(1, 'h180, 'h100, 0, 2, 1);
      run_cyc('h1A0, 5, 0, 6, 0, "R6 eq");
      // R3 window boundaries
      run_cyc('h1FF, 3, 0, 0, 0, "R3 last-in");
      run_cyc('h280, 3, 0, 0, 0, "R3 end");
      run_cyc('h0FF, 3, 0, 0, 0, "R3 below");
      // R3 zero size
      prog(2, 'h100, 0, 0, 7, 0);
      run_cyc('h150, 3, 0, 0, 0, "R3 size0");
      // R3 window reaching the top of the space
      prog(2, 'hFF00, 'h100, 0, 1, 0);
      run_cyc('hFFFF, 3, 0, 0, 0, "R3 top");
      // R1 space select
      prog(3, 'h00C0, 'h40, 1, 4, 0);
      run_cyc('h00F8, 1, 0, 0, 0, "R1 io");
      run_cyc('h00F8, 3, 0, 0, 0, "R1 mem-in-io");
      run_cyc('h0120, 2, 0, 0, 0, "R1 io-in-mem");
      // R11 window edges
      run_cyc('h00FF, 2, 0, 0, 0, "R11 top");
      run_cyc('h00F7, 1, 0, 0, 0, "R11 below");
      run_cyc('h0100, 1, 0, 3, 0, "R11 above");
      // R2 non-bus status
      run_cyc('h0150, 0, 0, 0, 0, "R2 idle");
      run_cyc('h0150, 6, 0, 0, 0, "R2 halt");
      run_cyc('h0150, 7, 0, 0, 0, "R2 rsvd");
      // R4 initiator tags
      for (int t = 0; t < 3; t++) run_cyc('h1C0, 3, t, 2, 0, "R4 init");
      // R10 start during busy is ignored
      run_cyc('h1A0, 3, 1, 5, 1, "R10 poke");

      // random traffic against the model
      for (int r = 0; r < 60; r++) begin
         for (int i = 0; i < N; i++)
            prog(i, $urandom % 'h180, ($urandom % 5 == 0) ? 0 : 1 + $urandom % 'h100,
                 1'($urandom % 3 == 0), $urandom % 16, 1'($urandom % 2));
         for (int c = 0; c < 6; c++)
            run_cyc($urandom % 'h200, $urandom % 8, $urandom % 3,
                    $urandom % 20, 1'($urandom % 4 == 0), "rand");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule